// File: doc/BRIEF.md
# Multi-CPU Auto-Masking Interrupt Controller

This block collects a set of level-sensitive interrupt lines and hands them out to several processors. Every line has one mask bit, one software trigger bit that is ORed onto the wire, and an affinity vector with one bit per CPU. A line is pending when its wire or its trigger bit is high. It reaches a CPU when it is pending, unmasked and affine to that CPU. Each CPU also owns two interchangeable inter-processor interrupt channels. Any CPU can raise them through that CPU's register view.

Each CPU has one event register. Reading it returns the winning source and masks that source in the same access, so the source stays quiet until software unmasks it. Requests on the two channels beat hardware lines. Among hardware lines the lowest number wins. A single register bus carries accesses from every CPU. A CPU-ID input tells the decoder who is asking, so one address window means "the accessing CPU" and further windows name each CPU explicitly. Each CPU has one level IRQ output.

Top module: `aic_top`

## Requirements
- R1: After reset every line mask and every channel mask is 1, every trigger bit and channel pending flag is 0, every affinity vector is 1 (CPU 0 only), all IRQ outputs are low and every event read returns 0.
- R2: Word address 0x040+w reads the pending level of lines 32w..32w+31, which is the wire ORed with the trigger bit. A line whose wire falls while its trigger bit is clear stops being pending at once.
- R3: A masked line is never reported by an event read and never raises an IRQ output. Word 0x000+w reads the mask bits.
- R4: Word 0x100+n holds the affinity of line n in its low NUM_CPU bits (bit c = CPU c). A line is reported only to CPUs whose bit is set.
- R5: When several hardware lines are eligible for a CPU, its event read reports the lowest-numbered one.
- R6: An event read that reports hardware line n sets mask bit n. Line n is then reported to no CPU until it is unmasked, and the next read reports the next eligible source.
- R7: Per-CPU offset 1 sets channel pending flags (bit k = channel k). A write from any CPU through a CPU's explicit view raises that CPU's channel. An eligible channel is reported before any hardware line, and channel 0 is reported before channel 1.
- R8: An event read that reports channel k sets that CPU's channel-k mask. Offset 2 clears pending flags and offset 3/4 set/clear channel masks. Offset 5 reads {mask[1:0], pending[1:0]} in bits 3:0.
- R9: The event word is kind in bits 17:16 (0 none, 1 hardware line, 2 channel) and the source number in bits 15:0, with all other bits 0. A read with nothing eligible returns 0 and changes no state.
- R10: Writes to 0x000+w and 0x040+w set and clear mask bits, and writes to 0x080+w and 0x0C0+w set and clear trigger bits (both read back the trigger bits). Only 1 bits act; 0 bits leave their bit unchanged.
- R11: Per-CPU registers sit at 0x200 + 16*view + offset. View 0 addresses the CPU given on bus_cpu, and view k+1 addresses CPU k. A view or bus_cpu that names no existing CPU reads 0 and has no effect.
- R12: Each IRQ output is high exactly when that CPU's event read would return a nonzero value. It follows input wires in the same cycle and register updates from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_irq | input | NUM_IRQ | Level interrupt wires |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | CPU_W | ID of the accessing CPU |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_out | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The bench builds the block with three CPUs and 40 lines. With these values the line set spans two mask words, and the second word is only partly filled, so the out-of-range bits must read 0. A two-bit CPU-ID input can also name a CPU that does not exist, which brings the invalid-view and invalid-ID paths within reach. Three CPUs allow one CPU to raise a channel on another through an explicit view while a third stays idle. Random traffic then mixes wire toggles, mask and trigger writes, affinity changes, channel operations and event reads through all views.

// File: rtl/aic_pkg.sv
package aic_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_HW   = 2'd1,
    EV_IPI  = 2'd2
  } ev_kind_e;

  typedef struct packed {
    logic [13:0] rsvd;
    ev_kind_e    kind;
    logic [15:0] num;
  } event_t;

  localparam logic [3:0] REGION_GLOBAL = 4'd0;
  localparam logic [3:0] REGION_AFF    = 4'd1;
  localparam logic [3:0] REGION_CPU    = 4'd2;

  localparam logic [1:0] GRP_MSET = 2'd0;
  localparam logic [1:0] GRP_MCLR = 2'd1;
  localparam logic [1:0] GRP_SSET = 2'd2;
  localparam logic [1:0] GRP_SCLR = 2'd3;

  localparam logic [3:0] OFF_EVENT = 4'd0;
  localparam logic [3:0] OFF_ISET  = 4'd1;
  localparam logic [3:0] OFF_ICLR  = 4'd2;
  localparam logic [3:0] OFF_IMSET = 4'd3;
  localparam logic [3:0] OFF_IMCLR = 4'd4;
  localparam logic [3:0] OFF_ISTAT = 4'd5;

  function automatic event_t make_event(ev_kind_e k, logic [15:0] n);
    event_t e;
    e.rsvd = '0;
    e.kind = k;
    e.num  = n;
    return e;
  endfunction
endpackage

// File: rtl/aic_src_bank.sv
module aic_src_bank #(
  parameter int NUM_IRQ = 48,
  parameter int NUM_CPU = 2,
  parameter int IDX_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_IRQ-1:0]                hw_irq,
  input  logic [NUM_IRQ-1:0]                mask_set_v,
  input  logic [NUM_IRQ-1:0]                mask_clr_v,
  input  logic [NUM_IRQ-1:0]                sw_set_v,
  input  logic [NUM_IRQ-1:0]                sw_clr_v,
  input  logic [NUM_IRQ-1:0]                ack_v,
  input  logic                              aff_we,
  input  logic [IDX_W-1:0]                  aff_idx,
  input  logic [NUM_CPU-1:0]                aff_wdata,
  output logic [NUM_IRQ-1:0]                mask_q,
  output logic [NUM_IRQ-1:0]                sw_q,
  output logic [NUM_IRQ-1:0]                pend_lvl,
  output logic [NUM_IRQ-1:0][NUM_CPU-1:0]   aff_q,
  output logic [NUM_CPU-1:0][NUM_IRQ-1:0]   elig
);
  localparam logic [NUM_CPU-1:0] AFF_RST = NUM_CPU'(1);

  // level view of each line: wire ORed with its software trigger
  assign pend_lvl = hw_irq | sw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= '0;
    end else begin
      mask_q <= (mask_q & ~mask_clr_v) | mask_set_v | ack_v;
      sw_q   <= (sw_q & ~sw_clr_v) | sw_set_v;
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_aff
    always_ff @(posedge clk) begin
      if (!rst_n)                                  aff_q[i] <= AFF_RST;
      else if (aff_we && aff_idx == IDX_W'(i))     aff_q[i] <= aff_wdata;
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign elig[c][i] = pend_lvl[i] & ~mask_q[i] & aff_q[i][c];
    end
  end

  p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_v));

  p_ack_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_v) |=> ((mask_q & $past(ack_v)) == $past(ack_v)));

  p_sw_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_clr_v && sw_set_v == '0) |=> ((sw_q & $past(sw_clr_v)) == '0));
endmodule

// File: rtl/aic_cpu_port.sv
module aic_cpu_port
  import aic_pkg::*;
#(
  parameter int NUM_IRQ = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] elig,
  input  logic [1:0]         ipi_set,
  input  logic [1:0]         ipi_clr,
  input  logic [1:0]         ipi_mset,
  input  logic [1:0]         ipi_mclr,
  input  logic               take,
  output event_t             evt,
  output logic [NUM_IRQ-1:0] hw_ack,
  output logic [3:0]         ipi_state,
  output logic               irq
);
  logic [1:0] ipi_pend, ipi_mask, ipi_live, ipi_take;
  logic [15:0] hw_num;

  function automatic logic [15:0] lowest_idx(input logic [NUM_IRQ-1:0] v);
    logic [15:0] r;
    r = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) if (v[i]) r = 16'(i);
    return r;
  endfunction

  function automatic logic [NUM_IRQ-1:0] below(input logic [15:0] n);
    logic [NUM_IRQ-1:0] r;
    for (int i = 0; i < NUM_IRQ; i++) r[i] = (32'(i) < 32'(n));
    return r;
  endfunction

  assign ipi_live  = ipi_pend & ~ipi_mask;
  assign hw_num    = lowest_idx(elig);
  assign ipi_state = {ipi_mask, ipi_pend};

  always_comb begin
    if (ipi_live[0])     evt = make_event(EV_IPI, 16'd0);
    else if (ipi_live[1]) evt = make_event(EV_IPI, 16'd1);
    else if (|elig)      evt = make_event(EV_HW, hw_num);
    else                 evt = make_event(EV_NONE, 16'd0);
  end

  always_comb begin
    hw_ack = '0;
    if (take && evt.kind == EV_HW) hw_ack[hw_num[$clog2(NUM_IRQ+1)-1:0]] = 1'b1;
  end

  assign ipi_take = (take && evt.kind == EV_IPI) ? (evt.num[0] ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipi_pend <= '0;
      ipi_mask <= '1;
    end else begin
      ipi_pend <= (ipi_pend & ~ipi_clr) | ipi_set;
      ipi_mask <= (ipi_mask & ~ipi_mclr) | ipi_mset | ipi_take;
    end
  end

  assign irq = (|elig) | (|ipi_live);

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.kind == EV_HW) |-> ((elig & below(evt.num)) == '0));

  p_ipi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ipi_live) |-> (evt.kind == EV_IPI));

  p_irq_matches_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (evt.kind != EV_NONE));

  p_ipi_take_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evt.kind == EV_IPI) |=> ipi_mask[$past(evt.num[0])]);

  p_empty_take_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && evt.kind == EV_NONE && ipi_mset == '0 && ipi_mclr == '0) |=> $stable(ipi_mask));
endmodule

// File: rtl/aic_top.sv
module aic_top
  import aic_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 48,
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] hw_irq,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [CPU_W-1:0]   bus_cpu,
  input  logic [11:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_CPU-1:0] irq_out
);
  localparam int IDX_W = 8;

  logic       rd, wr;
  logic [3:0] region, view, roff, tgt;
  logic [1:0] grp;
  logic [5:0] widx;
  logic       tgt_ok;

  assign rd     = bus_en & ~bus_we;
  assign wr     = bus_en & bus_we;
  assign region = bus_addr[11:8];
  assign grp    = bus_addr[7:6];
  assign widx   = bus_addr[5:0];
  assign view   = bus_addr[7:4];
  assign roff   = bus_addr[3:0];
  assign tgt    = (view == 4'd0) ? 4'(bus_cpu) : view - 4'd1;
  assign tgt_ok = (32'(tgt) < NUM_CPU);

  logic [NUM_IRQ-1:0] mask_set_v, mask_clr_v, sw_set_v, sw_clr_v, ack_v;
  logic [NUM_IRQ-1:0] mask_q, sw_q, pend_lvl;
  logic [NUM_IRQ-1:0][NUM_CPU-1:0] aff_q;
  logic [NUM_CPU-1:0][NUM_IRQ-1:0] elig, hw_ack;
  logic [NUM_CPU-1:0][3:0] ipi_state;
  event_t evt_arr [NUM_CPU];

  // decode of the write-one vectors, one bit per line
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_dec
    logic hit;
    assign hit           = wr && region == REGION_GLOBAL && widx == 6'(i / 32);
    assign mask_set_v[i] = hit && grp == GRP_MSET && bus_wdata[i % 32];
    assign mask_clr_v[i] = hit && grp == GRP_MCLR && bus_wdata[i % 32];
    assign sw_set_v[i]   = hit && grp == GRP_SSET && bus_wdata[i % 32];
    assign sw_clr_v[i]   = hit && grp == GRP_SCLR && bus_wdata[i % 32];
  end

  aic_src_bank #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_irq    (hw_irq),
    .mask_set_v(mask_set_v),
    .mask_clr_v(mask_clr_v),
    .sw_set_v  (sw_set_v),
    .sw_clr_v  (sw_clr_v),
    .ack_v     (ack_v),
    .aff_we    (wr && region == REGION_AFF),
    .aff_idx   (bus_addr[IDX_W-1:0]),
    .aff_wdata (bus_wdata[NUM_CPU-1:0]),
    .mask_q    (mask_q),
    .sw_q      (sw_q),
    .pend_lvl  (pend_lvl),
    .aff_q     (aff_q),
    .elig      (elig)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_port
    logic sel;
    assign sel = region == REGION_CPU && tgt_ok && tgt == 4'(c);
    aic_cpu_port #(.NUM_IRQ(NUM_IRQ)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .elig     (elig[c]),
      .ipi_set  ((wr && sel && roff == OFF_ISET)  ? bus_wdata[1:0] : 2'b00),
      .ipi_clr  ((wr && sel && roff == OFF_ICLR)  ? bus_wdata[1:0] : 2'b00),
      .ipi_mset ((wr && sel && roff == OFF_IMSET) ? bus_wdata[1:0] : 2'b00),
      .ipi_mclr ((wr && sel && roff == OFF_IMCLR) ? bus_wdata[1:0] : 2'b00),
      .take     (rd && sel && roff == OFF_EVENT),
      .evt      (evt_arr[c]),
      .hw_ack   (hw_ack[c]),
      .ipi_state(ipi_state[c]),
      .irq      (irq_out[c])
    );
  end

  always_comb begin
    ack_v = '0;
    for (int c = 0; c < NUM_CPU; c++) ack_v = ack_v | hw_ack[c];
  end

  function automatic logic [31:0] pick_word(input logic [NUM_IRQ-1:0] v, input logic [5:0] w);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++)
      if (int'(w) * 32 + b < NUM_IRQ) r[b] = v[int'(w) * 32 + b];
    return r;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (region)
        REGION_GLOBAL: begin
          unique case (grp)
            GRP_MSET: bus_rdata = pick_word(mask_q, widx);
            GRP_MCLR: bus_rdata = pick_word(pend_lvl, widx);
            default:  bus_rdata = pick_word(sw_q, widx);
          endcase
        end
        REGION_AFF: begin
          for (int i = 0; i < NUM_IRQ; i++)
            if (bus_addr[IDX_W-1:0] == IDX_W'(i)) bus_rdata = 32'(aff_q[i]);
        end
        REGION_CPU: begin
          for (int c = 0; c < NUM_CPU; c++) begin
            if (tgt_ok && tgt == 4'(c)) begin
              if (roff == OFF_EVENT)      bus_rdata = 32'(evt_arr[c]);
              else if (roff == OFF_ISTAT) bus_rdata = 32'(ipi_state[c]);
            end
          end
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  p_empty_read_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && region == REGION_CPU && roff == OFF_EVENT && bus_rdata == '0) |=> $stable(mask_q));

  p_bad_view_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && region == REGION_CPU && !tgt_ok) |-> (bus_rdata == '0));

  p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_lvl & ~mask_q) == '0) |-> (ack_v == '0));
endmodule

// File: tb/tb_aic_top.sv
module tb_aic_top;
  localparam int NC = 3;
  localparam int NI = 40;

  logic clk = 0, rst_n = 0;
  logic [NI-1:0] hw_irq = '0;
  logic bus_en = 0, bus_we = 0;
  logic [1:0] bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq_out;

  int n_tests = 0, n_fail = 0;

  bit [NI-1:0] m_mask, m_sw, m_hw;
  bit [NC-1:0] m_aff [NI];
  bit [1:0] m_ip [NC];
  bit [1:0] m_im [NC];

  always #10 clk = ~clk;

  aic_top #(.NUM_CPU(NC), .NUM_IRQ(NI)) dut (
    .clk(clk), .rst_n(rst_n), .hw_irq(hw_irq), .bus_en(bus_en), .bus_we(bus_we),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_event(int c);
    for (int k = 0; k < 2; k++)
      if (m_ip[c][k] && !m_im[c][k]) return {14'd0, 2'd2, 16'(k)};
    for (int i = 0; i < NI; i++)
      if ((m_hw[i] | m_sw[i]) && !m_mask[i] && m_aff[i][c]) return {14'd0, 2'd1, 16'(i)};
    return 32'd0;
  endfunction

  function automatic int target(int cpu, logic [11:0] a);
    return (a[7:4] == 0) ? cpu : int'(a[7:4]) - 1;
  endfunction

  task automatic check_irqs(input string req);
    logic [31:0] e;
    e = '0;
    for (int c = 0; c < NC; c++) e[c] = (exp_event(c) != 0);
    check(32'(irq_out), e, req);
  endtask

  task automatic set_hw(input int i, input bit v);
    @(negedge clk);
    m_hw[i] = v;
    hw_irq = m_hw;
    #1;
  endtask

  task automatic bw(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0;
    if (a[11:8] == 0) begin
      for (int b = 0; b < 32; b++) begin
        int idx = int'(a[5:0]) * 32 + b;
        if (idx < NI && d[b]) begin
          case (a[7:6])
            2'd0: m_mask[idx] = 1;
            2'd1: m_mask[idx] = 0;
            2'd2: m_sw[idx] = 1;
            default: m_sw[idx] = 0;
          endcase
        end
      end
    end else if (a[11:8] == 1) begin
      if (int'(a[7:0]) < NI) m_aff[a[7:0]] = d[NC-1:0];
    end else if (a[11:8] == 2) begin
      int t = target(cpu, a);
      if (t < NC) begin
        case (a[3:0])
          4'd1: m_ip[t] = m_ip[t] | d[1:0];
          4'd2: m_ip[t] = m_ip[t] & ~d[1:0];
          4'd3: m_im[t] = m_im[t] | d[1:0];
          4'd4: m_im[t] = m_im[t] & ~d[1:0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic br(input int cpu, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_cpu = 2'(cpu); bus_addr = a;
    #2 d = bus_rdata;
    @(posedge clk); #1;
    bus_en = 0;
  endtask

  // event read checked against the model, model updated on delivery
  task automatic ev_read(input int cpu, input int view, input string req);
    logic [31:0] d, e;
    logic [11:0] a;
    int t;
    a = 12'h200 | 12'(view << 4);
    t = target(cpu, a);
    e = (t < NC) ? exp_event(t) : 32'd0;
    br(cpu, a, d);
    check(d, e, req);
    if (t < NC) begin
      if (e[17:16] == 2'd1) m_mask[e[15:0]] = 1;
      if (e[17:16] == 2'd2) m_im[t][e[0]] = 1;
    end
  endtask

  logic [31:0] rdv;

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_mask = '1; m_sw = '0; m_hw = '0;
    for (int i = 0; i < NI; i++) m_aff[i] = 3'b001;
    for (int c = 0; c < NC; c++) begin m_ip[c] = 0; m_im[c] = 2'b11; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    check(32'(irq_out), 0, "R1 irq_out");
    br(0, 12'h000, rdv); check(rdv, 32'hFFFF_FFFF, "R1 mask word0");
    br(0, 12'h001, rdv); check(rdv, 32'h0000_00FF, "R1 mask word1");
    br(0, 12'h105, rdv); check(rdv, 32'h1, "R1 affinity");
    br(1, 12'h205, rdv); check(rdv, 32'hC, "R1 ipi state");
    for (int c = 0; c < NC; c++) ev_read(c, 0, "R1 empty event");

    // R2 pending level
    set_hw(3, 1);
    br(0, 12'h040, rdv); check(rdv, 32'h8, "R2 wire pending");
    bw(0, 12'h080, 32'h80);
    br(0, 12'h080, rdv); check(rdv, 32'h80, "R10 trigger set");
    br(0, 12'h040, rdv); check(rdv, 32'h88, "R2 wire or trigger");
    bw(0, 12'h0C0, 32'h80);
    br(0, 12'h0C0, rdv); check(rdv, 32'h0, "R10 trigger clear");
    check(32'(irq_out), 0, "R3 masked line silent");

    // R3 / R10 unmask, zero writes ignored
    bw(0, 12'h040, 32'h8);
    check(32'(irq_out), 32'h1, "R3 unmasked raises cpu0");
    bw(0, 12'h040, 32'h0);
    bw(0, 12'h000, 32'h0);
    br(0, 12'h000, rdv); check(rdv, 32'hFFFF_FFF7, "R10 zero bits no effect");

    // R4 affinity
    bw(0, 12'h103, 32'h2);
    check(32'(irq_out), 32'h2, "R4 affinity moves line");
    set_hw(3, 0);
    check(32'(irq_out), 32'h0, "R2 wire fall drops");
    set_hw(3, 1);

    // R5 / R6 priority and auto-mask
    bw(0, 12'h040, 32'h400);
    bw(0, 12'h041, 32'h8);
    bw(0, 12'h10A, 32'h6);
    bw(0, 12'h123, 32'h2);
    bw(0, 12'h080, 32'h400);
    set_hw(35, 1);
    br(1, 12'h200, rdv); check(rdv, 32'h0001_0003, "R5 lowest wins");
    m_mask[3] = 1;
    br(0, 12'h000, rdv); check(rdv[3], 1'b1, "R6 delivery masks");
    ev_read(1, 0, "R6 next source");
    ev_read(2, 3, "R6 masked not offered elsewhere");
    ev_read(1, 2, "R11 explicit view");
    check_irqs("R12 irq after deliveries");

    // R7 / R8 inter-processor channels
    bw(2, 12'h211, 32'h2);
    br(0, 12'h205, rdv); check(rdv, 32'hE, "R7 raise from other cpu");
    bw(0, 12'h204, 32'h3);
    bw(0, 12'h040, 32'h20);
    bw(0, 12'h080, 32'h20);
    br(0, 12'h200, rdv); check(rdv, 32'h0002_0001, "R7 channel beats line");
    m_im[0][1] = 1;
    br(0, 12'h200, rdv); check(rdv, 32'h0001_0005, "R8 channel masked by read");
    m_mask[5] = 1;
    br(0, 12'h205, rdv); check(rdv, 32'hA, "R8 ipi state");
    bw(0, 12'h202, 32'h2);
    bw(0, 12'h204, 32'h2);
    br(0, 12'h205, rdv); check(rdv, 32'h0, "R8 acknowledged");
    bw(1, 12'h211, 32'h3);
    ev_read(0, 1, "R7 channel 0 first");

    // R9 empty read, R11 invalid view
    br(0, 12'h000, rdv);
    ev_read(2, 0, "R9 empty read zero");
    begin
      logic [31:0] r2;
      br(0, 12'h000, r2); check(r2, rdv, "R9 empty read no effect");
    end
    ev_read(3, 0, "R11 invalid cpu id");
    ev_read(0, 4, "R11 invalid view");

    // constrained random traffic
    for (int it = 0; it < 500; it++) begin
      int op = $urandom_range(0, 8);
      int cpu = $urandom_range(0, NC - 1);
      case (op)
        0: set_hw($urandom_range(0, NI - 1), 1'($urandom));
        1: bw(cpu, 12'h040 | 12'($urandom_range(0, 1)), $urandom & $urandom);
        2: bw(cpu, 12'h000 | 12'($urandom_range(0, 1)), $urandom & $urandom & $urandom);
        3: bw(cpu, 12'h080 | 12'($urandom_range(0, 1)), $urandom & $urandom & $urandom);
        4: bw(cpu, 12'h0C0 | 12'($urandom_range(0, 1)), $urandom);
        5: bw(cpu, 12'h100 | 12'($urandom_range(0, NI - 1)), 32'($urandom_range(0, 7)));
        6: bw(cpu, 12'h200 | 12'($urandom_range(0, 3) << 4) | 12'($urandom_range(1, 4)),
              32'($urandom_range(0, 3)));
        default: ev_read(cpu, $urandom_range(0, 4), "R5 R6 R7 random event");
      endcase
      check_irqs("R12 random irq_out");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule